// File: doc/BRIEF.md
# HDLC Receive Controller with Ping-Pong Message Buffers

This block recovers HDLC/LAPD frames from a serial data-link bit stream. Each line bit arrives with a valid strobe. The block strips stuffed zeros and finds frame boundaries at the flag octet 0x7E. It treats a run of seven ones as an abort. Every complete frame, including its two frame check octets, is written into one of two byte buffers. Successive frames alternate between the two buffers.

When a frame closes, the block latches a status word and can raise a message interrupt. The status word gives the buffer index, the stored byte count and the CRC-16 result. The host reads the status, then pulls exactly that many bytes from the matching read port. Each read port steps its own address on every read strobe.

A second interrupt supports signalling links that must reject overlong frames. When that check is switched on, the interrupt fires as soon as a frame grows past 276 bytes between its flags.

The deframer runs a three-state machine:
- `ST_HUNT`: waiting for the first flag.
- `ST_SYNC`: a flag has been seen and no byte is complete yet.
- `ST_FRAME`: at least one byte is held.

Its transitions are:
- HUNT→SYNC on a flag.
- SYNC→FRAME when the first byte completes.
- SYNC→SYNC on a repeated flag.
- FRAME→SYNC on a closing flag. The frame is posted if it holds whole bytes and dropped if it does not.
- SYNC→HUNT or FRAME→HUNT on an abort.

Top module: `hdlc_rx_ctrl`

## Requirements
- R1: After reset, both interrupts are low, the status word is all zero, and the first posted frame goes to buffer 0.
- R2: A 0 received right after five consecutive 1s is discarded. Data bytes are assembled least significant bit first from the remaining bits.
- R3: A frame is the whole-byte content between two flags (0x7E). When the closing flag's last bit is taken, `stat_cnt` reports the number of bytes received, counting the two check octets. Back-to-back flags with no bytes between them post nothing.
- R4: Posted frames alternate buffers, 0, 1, 0, …, and `stat_buf` names the buffer that holds the latest frame.
- R5: Each buffer has its own read port. The port shows the byte at its read pointer and advances the pointer by one per read strobe. The pointer returns to byte 0 whenever a new frame is posted into that buffer.
- R6: Seven or more consecutive 1s abort the current frame. The frame is not posted, raises no interrupt and does not advance the buffer alternation.
- R7: `stat_crc_ok` is 1 when the CRC-16 over all frame bytes leaves the good residue, and 0 otherwise. The CRC uses reflected polynomial 0x8408, preset 0xFFFF and residue 0xF0B8.
- R8: `irq_eom` is set on a frame post only while the message-interrupt enable is 1. That enable is bit 0 written at `cfg_addr` 0. `eom_ack` clears `irq_eom`.
- R9: The SS7 length check is on only after the value 0x01 is written at `cfg_addr` 1; any other value turns it off. While the check is on, `irq_ss7` sets when the 277th byte of a frame arrives, and it does not set for a 276-byte frame. `ss7_ack` clears it.
- R10: Bytes past `BUF_DEPTH` are not stored, and `stat_cnt` is capped at `BUF_DEPTH`.
- R11: A frame whose bit count between flags is not a multiple of eight is dropped without a post or an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_bit | input | 1 | Serial data-link bit |
| line_vld | input | 1 | Qualifies `line_bit` for this cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0: message-interrupt enable, 1: SS7 length check |
| cfg_wdata | input | 8 | Configuration write data |
| rd0_en | input | 1 | Read strobe for buffer 0 |
| rd0_data | output | 8 | Byte at the buffer 0 read pointer |
| rd1_en | input | 1 | Read strobe for buffer 1 |
| rd1_data | output | 8 | Byte at the buffer 1 read pointer |
| stat_buf | output | 1 | Buffer that holds the latest frame |
| stat_cnt | output | clog2(BUF_DEPTH+1), 6 by default | Stored byte count of the latest frame |
| stat_crc_ok | output | 1 | CRC result of the latest frame |
| irq_eom | output | 1 | Message-complete interrupt |
| eom_ack | input | 1 | Clears `irq_eom` |
| irq_ss7 | output | 1 | Overlong-frame interrupt |
| ss7_ack | input | 1 | Clears `irq_ss7` |

## Verification
The deframer assertions assume the line follows HDLC transmit rules: a stuffing zero always follows any five data ones, and every frame opens with a flag. The bench's transmit model counts ones across byte edges and inserts the zero itself, so the stimulus keeps within those rules. The only deliberate breaks are the abort run of ones and the frame that stops mid-byte. The buffer assertions assume a host never strobes a read port in the same cycle a frame is posted to it. The bench performs all reads only after a post, while the line is between frames.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_SYNC,
        ST_FRAME
    } dfr_state_t;

    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
    localparam logic [15:0] CRC_POLY_R  = 16'h8408;

    // One byte of CRC-16 with reflected polynomial, bit 0 of the byte first.
    function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_R;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_bit,
    input  logic       line_vld,
    output logic       byte_we,
    output logic [7:0] byte_data,
    output logic       frame_end,
    output logic       frame_drop
);

    dfr_state_t state_q, state_d;
    logic [2:0] ones_q;
    logic [2:0] bitcnt_q;
    logic [7:0] sr_q;
    logic [7:0] pend_q;

    logic hit_flag, hit_stuff, hit_abort, push, byte_full, aligned;

    always_comb begin
        hit_flag  = line_vld && !line_bit && (ones_q == 3'd6);
        hit_stuff = line_vld && !line_bit && (ones_q == 3'd5);
        hit_abort = line_vld &&  line_bit && (ones_q >= 3'd6);
        push      = line_vld && !hit_flag && !hit_stuff && !hit_abort
                    && (state_q != ST_HUNT);
        byte_full = push && (bitcnt_q == 3'd7);
        aligned   = (bitcnt_q == 3'd7);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (hit_flag) state_d = ST_SYNC;
            end
            ST_SYNC: begin
                if (hit_abort)      state_d = ST_HUNT;
                else if (hit_flag)  state_d = ST_SYNC;
                else if (byte_full) state_d = ST_FRAME;
            end
            ST_FRAME: begin
                if (hit_abort)     state_d = ST_HUNT;
                else if (hit_flag) state_d = ST_SYNC;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // State register and bit datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_HUNT;
            ones_q   <= '0;
            bitcnt_q <= '0;
            sr_q     <= '0;
            pend_q   <= '0;
        end else begin
            state_q <= state_d;
            if (line_vld) begin
                if (line_bit) ones_q <= (ones_q == 3'd7) ? ones_q : ones_q + 3'd1;
                else          ones_q <= '0;
            end
            if (hit_flag || hit_abort) bitcnt_q <= '0;
            else if (push)             bitcnt_q <= bitcnt_q + 3'd1;
            if (push)      sr_q   <= {line_bit, sr_q[7:1]};
            if (byte_full) pend_q <= {line_bit, sr_q[7:1]};
        end
    end

    // Outputs: a byte is released one byte late, so flag bits never reach memory
    always_comb begin
        byte_data  = pend_q;
        frame_end  = (state_q == ST_FRAME) && hit_flag && aligned;
        frame_drop = (state_q == ST_FRAME) && (hit_abort || (hit_flag && !aligned));
        byte_we    = (state_q == ST_FRAME) && (byte_full || (hit_flag && aligned));
    end

    AST_STUFF_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (line_vld && !line_bit && ones_q == 3'd5) |=> $stable(bitcnt_q)); // R2
    AST_FLAG_REALIGNS: assert property (@(posedge clk) disable iff (!rst_n)
        (line_vld && !line_bit && ones_q == 3'd6) |=> (bitcnt_q == 3'd0 && state_q == ST_SYNC)); // R3
    AST_ABORT_HUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (line_vld && line_bit && ones_q >= 3'd6) |=> (state_q == ST_HUNT)); // R6

endmodule

// File: rtl/hdlc_rx_bank.sv
module hdlc_rx_bank #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          ptr_clr,
    input  logic          rd_en,
    output logic [7:0]    rdata
);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] rptr_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       rptr_q <= '0;
        else if (ptr_clr) rptr_q <= '0;
        else if (rd_en)   rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    end

    assign rdata = mem[rptr_q];

    AST_RPTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |=> (rptr_q == '0)); // R5

endmodule

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl
    import hdlc_rx_pkg::*;
#(
    parameter int BUF_DEPTH = 32,
    parameter int SS7_LIMIT = 276,
    parameter int CW        = $clog2(BUF_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_bit,
    input  logic          line_vld,
    input  logic          cfg_we,
    input  logic          cfg_addr,
    input  logic [7:0]    cfg_wdata,
    input  logic          rd0_en,
    output logic [7:0]    rd0_data,
    input  logic          rd1_en,
    output logic [7:0]    rd1_data,
    output logic          stat_buf,
    output logic [CW-1:0] stat_cnt,
    output logic          stat_crc_ok,
    output logic          irq_eom,
    input  logic          eom_ack,
    output logic          irq_ss7,
    input  logic          ss7_ack
);

    localparam int AW = $clog2(BUF_DEPTH);
    localparam int RW = $clog2(SS7_LIMIT + 2);

    logic          byte_we, frame_end, frame_drop;
    logic [7:0]    byte_data;
    logic          wr_sel_q;
    logic [RW-1:0] rx_cnt_q, cnt_nx;
    logic [15:0]   crc_q, crc_nx;
    logic [CW-1:0] stored_nx;
    logic          eom_ie_q, ss7_en_q;
    logic          bank_we;
    logic [1:0]    bk_rd_en;
    logic [7:0]    bk_rdata [2];

    hdlc_rx_deframer u_deframer (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_bit   (line_bit),
        .line_vld   (line_vld),
        .byte_we    (byte_we),
        .byte_data  (byte_data),
        .frame_end  (frame_end),
        .frame_drop (frame_drop)
    );

    always_comb begin
        cnt_nx    = (rx_cnt_q == RW'(SS7_LIMIT + 1)) ? rx_cnt_q : rx_cnt_q + 1'b1;
        crc_nx    = crc16_byte(crc_q, byte_data);
        stored_nx = (cnt_nx >= RW'(BUF_DEPTH)) ? CW'(BUF_DEPTH) : CW'(cnt_nx);
        bank_we   = byte_we && (rx_cnt_q < RW'(BUF_DEPTH));
        bk_rd_en  = {rd1_en, rd0_en};
    end

    for (genvar g = 0; g < 2; g++) begin : g_bank
        hdlc_rx_bank #(.DEPTH(BUF_DEPTH), .AW(AW)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (bank_we && (wr_sel_q == 1'(g))),
            .waddr   (AW'(rx_cnt_q)),
            .wdata   (byte_data),
            .ptr_clr (frame_end && (wr_sel_q == 1'(g))),
            .rd_en   (bk_rd_en[g]),
            .rdata   (bk_rdata[g])
        );
    end

    assign rd0_data = bk_rdata[0];
    assign rd1_data = bk_rdata[1];

    // Frame accumulation, status and configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_sel_q    <= 1'b0;
            rx_cnt_q    <= '0;
            crc_q       <= CRC_PRESET;
            stat_buf    <= 1'b0;
            stat_cnt    <= '0;
            stat_crc_ok <= 1'b0;
            eom_ie_q    <= 1'b0;
            ss7_en_q    <= 1'b0;
        end else begin
            if (cfg_we && !cfg_addr) eom_ie_q <= cfg_wdata[0];
            if (cfg_we &&  cfg_addr) ss7_en_q <= (cfg_wdata == 8'h01);
            if (frame_end) begin
                stat_buf    <= wr_sel_q;
                stat_cnt    <= stored_nx;
                stat_crc_ok <= (crc_nx == CRC_RESIDUE);
                wr_sel_q    <= ~wr_sel_q;
                rx_cnt_q    <= '0;
                crc_q       <= CRC_PRESET;
            end else if (frame_drop) begin
                rx_cnt_q    <= '0;
                crc_q       <= CRC_PRESET;
            end else if (byte_we) begin
                rx_cnt_q    <= cnt_nx;
                crc_q       <= crc_nx;
            end
        end
    end

    // Interrupt outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_eom <= 1'b0;
            irq_ss7 <= 1'b0;
        end else begin
            if (frame_end && eom_ie_q) irq_eom <= 1'b1;
            else if (eom_ack)          irq_eom <= 1'b0;
            if (byte_we && ss7_en_q && rx_cnt_q == RW'(SS7_LIMIT)) irq_ss7 <= 1'b1;
            else if (ss7_ack)                                       irq_ss7 <= 1'b0;
        end
    end

    AST_EOM_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_eom) |-> $past(eom_ie_q)); // R8
    AST_SS7_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_ss7) |-> $past(ss7_en_q)); // R9
    AST_POST_FLIPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (stat_buf != wr_sel_q)); // R4
    AST_COUNT_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        stat_cnt <= CW'(BUF_DEPTH)); // R10

endmodule

// File: tb/test_hdlc_rx_ctrl.sv
module test_hdlc_rx_ctrl;

    localparam int DEPTH = 32;
    localparam int LIMIT = 276;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_bit = 1'b0, line_vld = 1'b0;
    logic       cfg_we = 1'b0, cfg_addr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       rd0_en = 1'b0, rd1_en = 1'b0;
    logic [7:0] rd0_data, rd1_data;
    logic       stat_buf, stat_crc_ok, irq_eom, irq_ss7;
    logic [5:0] stat_cnt;
    logic       eom_ack = 1'b0, ss7_ack = 1'b0;

    always #5 clk = ~clk;

    hdlc_rx_ctrl #(.BUF_DEPTH(DEPTH), .SS7_LIMIT(LIMIT)) i_hdlc_rx_ctrl (
        .clk(clk), .rst_n(rst_n), .line_bit(line_bit), .line_vld(line_vld),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rd0_en(rd0_en), .rd0_data(rd0_data), .rd1_en(rd1_en), .rd1_data(rd1_data),
        .stat_buf(stat_buf), .stat_cnt(stat_cnt), .stat_crc_ok(stat_crc_ok),
        .irq_eom(irq_eom), .eom_ack(eom_ack), .irq_ss7(irq_ss7), .ss7_ack(ss7_ack)
    );

    int n_chk = 0, n_err = 0;
    int tx_ones = 0, gap_cnt = 0, exp_buf = 0, fr_len = 0;
    bit gap_en = 1'b0;
    logic [7:0] fr [0:511];

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        line_bit = b; line_vld = 1'b1;
        @(negedge clk);
        line_vld = 1'b0;
        gap_cnt++;
        if (gap_en && (gap_cnt % 5 == 0)) @(negedge clk);
    endtask

    task automatic flag_out();
        bit_out(1'b0);
        for (int i = 0; i < 6; i++) bit_out(1'b1);
        bit_out(1'b0);
        tx_ones = 0;
    endtask

    task automatic data_bit(input logic b);
        bit_out(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin bit_out(1'b0); tx_ones = 0; end
        end else tx_ones = 0;
    endtask

    task automatic byte_out(input logic [7:0] v);
        for (int i = 0; i < 8; i++) data_bit(v[i]);
    endtask

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ 16'h8408;
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic build(input int len, input int seed);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 0; i < len; i++) fr[i] = 8'((i * 53 + seed * 17 + 5) & 255);
        if (len >= 1) fr[0] = 8'hFF;
        if (len >= 2) fr[len-1] = 8'h7E;
        for (int i = 0; i < len; i++) c = crc_upd(c, fr[i]);
        c = ~c;
        fr[len] = c[7:0];
        fr[len+1] = c[15:8];
        fr_len = len + 2;
    endtask

    task automatic send_frame(input bit bad_fcs);
        flag_out();
        for (int i = 0; i < fr_len; i++)
            byte_out((bad_fcs && i == fr_len - 1) ? (fr[i] ^ 8'h01) : fr[i]);
        flag_out();
    endtask

    task automatic read_check(input int which, input int n);
        for (int j = 0; j < n; j++) begin
            check("R5/R2", "read byte", int'(which ? rd1_data : rd0_data), int'(fr[j]));
            if (which != 0) rd1_en = 1'b1; else rd0_en = 1'b1;
            @(negedge clk);
            rd0_en = 1'b0; rd1_en = 1'b0;
        end
    endtask

    task automatic post_check(input int crc_exp);
        int n;
        n = (fr_len > DEPTH) ? DEPTH : fr_len;
        check("R4", "stat_buf", int'(stat_buf), exp_buf);
        check(fr_len > DEPTH ? "R10" : "R3", "stat_cnt", int'(stat_cnt), n);
        check("R7", "stat_crc_ok", int'(stat_crc_ok), crc_exp);
        read_check(exp_buf, n);
        exp_buf ^= 1;
    endtask

    task automatic cfg(input logic a, input logic [7:0] d);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic ack_eom();
        eom_ack = 1'b1; @(negedge clk); eom_ack = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int keep_cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "irq_eom", int'(irq_eom), 0);
        check("R1", "irq_ss7", int'(irq_ss7), 0);
        check("R1", "stat_cnt", int'(stat_cnt), 0);
        check("R1", "stat_buf", int'(stat_buf), 0);
        check("R1", "stat_crc_ok", int'(stat_crc_ok), 0);
        for (int i = 0; i < 10; i++) bit_out(1'b1);
        cfg(1'b0, 8'h01);

        // Sweep of frame lengths; R2 via 0xFF/0x7E payload bytes, R3/R4/R5/R7/R8
        for (int len = 1; len <= 12; len++) begin
            gap_en = (len % 2 == 0);
            build(len, len);
            send_frame(1'b0);
            check("R8", "irq_eom set", int'(irq_eom), 1);
            post_check(1);
            ack_eom();
            check("R8", "irq_eom cleared", int'(irq_eom), 0);
        end
        gap_en = 1'b0;

        // R3: idle flags post nothing
        keep_cnt = int'(stat_cnt);
        for (int i = 0; i < 4; i++) flag_out();
        check("R3", "no post on idle flags", int'(irq_eom), 0);
        check("R3", "stat_cnt kept", int'(stat_cnt), keep_cnt);

        // R7: corrupted check octet
        build(5, 40);
        send_frame(1'b1);
        fr[fr_len-1] = fr[fr_len-1] ^ 8'h01;
        post_check(0);
        ack_eom();

        // R6: abort mid-frame
        keep_cnt = int'(stat_cnt);
        flag_out();
        byte_out(8'h12); byte_out(8'h34); byte_out(8'h56);
        for (int i = 0; i < 8; i++) bit_out(1'b1);
        tx_ones = 0;
        check("R6", "no irq after abort", int'(irq_eom), 0);
        check("R6", "stat_cnt kept", int'(stat_cnt), keep_cnt);
        build(3, 7);
        send_frame(1'b0);
        post_check(1);
        ack_eom();

        // R11: frame not a multiple of eight bits
        keep_cnt = int'(stat_cnt);
        flag_out();
        byte_out(8'h55); byte_out(8'h0F);
        data_bit(1'b1); data_bit(1'b0); data_bit(1'b1);
        flag_out();
        check("R11", "no irq on ragged frame", int'(irq_eom), 0);
        check("R11", "stat_cnt kept", int'(stat_cnt), keep_cnt);

        // R8: interrupt disabled, status still posted
        cfg(1'b0, 8'h00);
        build(4, 9);
        send_frame(1'b0);
        check("R8", "irq_eom stays low", int'(irq_eom), 0);
        post_check(1);
        cfg(1'b0, 8'h01);

        // R9/R10: SS7 length limit
        cfg(1'b1, 8'h01);
        build(LIMIT - 2, 3);
        send_frame(1'b0);
        check("R9", "276 bytes no ss7", int'(irq_ss7), 0);
        post_check(1);
        ack_eom();
        build(LIMIT - 1, 4);
        send_frame(1'b0);
        check("R9", "277 bytes ss7", int'(irq_ss7), 1);
        post_check(1);
        ack_eom();
        ss7_ack = 1'b1; @(negedge clk); ss7_ack = 1'b0;
        check("R9", "ss7 cleared", int'(irq_ss7), 0);
        cfg(1'b1, 8'h03);
        build(298, 5);
        send_frame(1'b0);
        check("R9", "ss7 off for 0x03", int'(irq_ss7), 0);
        post_check(1);
        ack_eom();

        finish_run();
    end

endmodule